// File: doc/BRIEF.md
# Daisy-Chain Input Serializer Readout Controller

This block is the host-side readout controller for a chain of identical eight-input serializers that share one SPI bus. Each chip in the chain shifts out a data byte. In status mode it also shifts out a status byte after the data byte. When the status byte is present, its top five bits carry a check code over the data byte, and its low three bits carry temperature and supply flags.

A read request starts one SPI transfer. Chip-select stays low for the whole transfer, which is `N_CHIPS × wordlen` bytes long, where wordlen is 2 in status mode and 1 in data-only mode. After the last bit arrives, the block does three things in the same cycle. It splits the received stream into per-chip fields, checks every chip's status, and samples the fault pins. It then publishes the 8·N input bits, a per-chip fault vector and the per-chip diagnostic flags, and pulses `done`. A chip found faulting has its eight input bits forced to zero. Healthy chips in the same chain still report their inputs normally.

The request side is a valid/ready handshake. The requester raises `req_valid` and holds it until it sees `req_ready` high at a clock edge. The block accepts the request on that edge, and `req_ready` stays low until the frame has been received. The results carry no back-pressure. They are held registers that change only at the `done` pulse, and each transfer replaces them.

Top module: `sser_chain_rd`

## Requirements
- R1: `req_ready` is high whenever no transfer is running. A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` and `cs_n` are never low and high respectively at the same time as a transfer runs: while `cs_n` is low, `req_ready` is low. A `req_valid` held during a transfer has no effect on that transfer.
- R2: Timing and bus mode. The SPI bus uses mode 0: `sclk` idles low, each bit is sampled on the rising edge, and each `sclk` half period lasts `CLK_DIV` clock cycles. `cs_n` stays low for exactly `2·CLK_DIV·8·N_CHIPS·wordlen` cycles. `done` is a single-cycle pulse one cycle after `cs_n` rises.
- R3: Byte order and bit mapping. Bytes arrive most significant bit first. In status mode, chip i's data byte is received byte 2i and its status byte is received byte 2i+1. In data-only mode, chip i's data byte is received byte i. Input bit k on `in_bits` is bit k mod 8 of chip k/8's data byte.
- R4: Check code. In status mode, a chip's CRC-error flag is set when status bits 7..3 differ from the check code of its data byte. The check code uses polynomial x^5+x^4+x^2+1, is computed MSB first from a zero start, and is held left-aligned in bits 7..3.
- R5: Status bit 1 is an active-high overtemperature alarm. When set, it raises `over_temp` for that chip and makes the chip faulting.
- R6: Status bit 2 is an active-low undervoltage alarm, which makes the chip faulting. Status bit 0 is an active-low undervoltage warning, which raises `uv_warn` but never makes the chip faulting by itself.
- R7: While `ignore_uv` (latched at request acceptance) is high, both undervoltage flags read 0 and the fault pins have no effect.
- R8: In data-only mode, `crc_err`, `over_temp`, `uv_alarm` and `uv_warn` read 0, and the fault pin is the only source of a chip fault.
- R9: Fault pins are sampled when the frame completes. With `SHARED_FAULT`=0 there is one pin per chip, and pin i faults chip i. With `SHARED_FAULT`=1 there is a single pin, and it faults every chip.
- R10: A faulting chip's eight bits on `in_bits` read 0. Non-faulting chips show their received data byte.
- R11: All result outputs hold their values between `done` pulses.
- R12: After reset, `cs_n`=1, `sclk`=0, `req_ready`=1, `done`=0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_mode | input | 1 | 1: each chip sends data and status bytes; 0: data byte only (latched on accept) |
| ignore_uv | input | 1 | Suppress undervoltage flags and fault pins (latched on accept) |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle, request can be accepted |
| sclk | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | SPI chip-select, active low |
| miso | input | 1 | SPI serial data from the chain |
| fault_pin | input | FP_W | Fault inputs, active high: 1 bit if SHARED_FAULT else N_CHIPS |
| done | output | 1 | One-cycle pulse when new results are published |
| in_bits | output | 8·N_CHIPS | Input states, zero for faulting chips |
| chip_fault | output | N_CHIPS | Per-chip fault |
| crc_err | output | N_CHIPS | Per-chip check code mismatch |
| over_temp | output | N_CHIPS | Per-chip overtemperature alarm |
| uv_alarm | output | N_CHIPS | Per-chip undervoltage alarm |
| uv_warn | output | N_CHIPS | Per-chip undervoltage warning |

## Verification
A miscounted bit or divider counter shows up at the ports as a `cs_n` window of the wrong length, or as a `done` pulse on the wrong cycle. The bench's cycle model catches either within one frame, on the first cycle it diverges. A mis-indexed byte extraction, or a wrong latched mode, moves one chip's data or status into another chip's slot. That appears at the first `done` as wrong bits or flags on that chip. A stale flag or result register that updates outside `done` is caught on the very next cycle by the per-cycle comparison of the held outputs.

// File: rtl/sser_pkg.sv
package sser_pkg;

  // Per-chip diagnostic record produced by the evaluator
  typedef struct packed {
    logic crc_bad;
    logic hot;
    logic uv_al;
    logic uv_wn;
    logic flt;
  } chip_diag_t;

  localparam logic [7:0] CHK_POLY = 8'hA8;

  // 5-bit check code over one byte, MSB first, zero start, left-aligned
  function automatic logic [4:0] chk5(input logic [7:0] d);
    logic [7:0] r;
    r = d;
    for (int b = 0; b < 8; b++) begin
      if (r[7]) r = {r[6:0], 1'b0} ^ CHK_POLY;
      else      r = {r[6:0], 1'b0};
    end
    return r[7:3];
  endfunction

endpackage

// File: rtl/sser_spi_rx.sv
module sser_spi_rx #(
  parameter int CLK_DIV = 2,
  parameter int BUF_W   = 48,
  localparam int BCW    = $clog2(BUF_W + 1),
  localparam int DCW    = $clog2(CLK_DIV) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BCW-1:0]   nbits,
  input  logic             miso,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             fin,
  output logic [BUF_W-1:0] rxb
);

  logic [DCW-1:0] dcnt;
  logic [BCW-1:0] bcnt;
  logic [BCW-1:0] nb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      sclk <= 1'b0;
      busy <= 1'b0;
      fin  <= 1'b0;
      dcnt <= '0;
      bcnt <= '0;
      nb_q <= '0;
      rxb  <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cs_n <= 1'b0;
          dcnt <= '0;
          bcnt <= '0;
          nb_q <= nbits;
        end
      end else if (dcnt == DCW'(CLK_DIV - 1)) begin
        dcnt <= '0;
        sclk <= ~sclk;
        if (!sclk) begin
          rxb <= {rxb[BUF_W-2:0], miso};          // rising edge: sample
        end else if (bcnt == nb_q - BCW'(1)) begin
          busy <= 1'b0;                           // last falling edge
          cs_n <= 1'b1;
          fin  <= 1'b1;
        end else begin
          bcnt <= bcnt + BCW'(1);
        end
      end else begin
        dcnt <= dcnt + DCW'(1);
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);  // R2
  AST_BITCOUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < nb_q));  // R2

endmodule

// File: rtl/sser_chip_eval.sv
module sser_chip_eval
  import sser_pkg::*;
(
  input  logic       st_mode,
  input  logic       ign_uv,
  input  logic [7:0] data,
  input  logic [7:0] stat,
  input  logic       pin,
  output chip_diag_t diag,
  output logic [7:0] bits
);

  logic pin_f;

  always_comb begin
    pin_f        = pin && !ign_uv;
    diag.crc_bad = st_mode && (stat[7:3] != chk5(data));
    diag.hot     = st_mode && stat[1];
    diag.uv_al   = st_mode && !ign_uv && !stat[2];
    diag.uv_wn   = st_mode && !ign_uv && !stat[0];
    diag.flt     = pin_f || diag.crc_bad || diag.hot || diag.uv_al;
    bits         = diag.flt ? 8'h00 : data;
  end

endmodule

// File: rtl/sser_chain_rd.sv
module sser_chain_rd
  import sser_pkg::*;
#(
  parameter int N_CHIPS      = 3,
  parameter int CLK_DIV      = 2,
  parameter int SHARED_FAULT = 0,
  localparam int FP_W        = (SHARED_FAULT != 0) ? 1 : N_CHIPS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 status_mode,
  input  logic                 ignore_uv,
  input  logic                 req_valid,
  output logic                 req_ready,
  output logic                 sclk,
  output logic                 cs_n,
  input  logic                 miso,
  input  logic [FP_W-1:0]      fault_pin,
  output logic                 done,
  output logic [8*N_CHIPS-1:0] in_bits,
  output logic [N_CHIPS-1:0]   chip_fault,
  output logic [N_CHIPS-1:0]   crc_err,
  output logic [N_CHIPS-1:0]   over_temp,
  output logic [N_CHIPS-1:0]   uv_alarm,
  output logic [N_CHIPS-1:0]   uv_warn
);

  localparam int BUF_W = 16 * N_CHIPS;
  localparam int BCW   = $clog2(BUF_W + 1);

  logic             busy, fin, start, mode_q, ign_q;
  logic [BUF_W-1:0] rxb;
  logic [BCW-1:0]   nbits;

  assign req_ready = !busy;
  assign start     = req_valid && !busy;
  assign nbits     = status_mode ? BCW'(16 * N_CHIPS) : BCW'(8 * N_CHIPS);

  sser_spi_rx #(.CLK_DIV(CLK_DIV), .BUF_W(BUF_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .nbits(nbits), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .fin(fin), .rxb(rxb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ign_q  <= 1'b0;
    end else if (start) begin
      mode_q <= status_mode;
      ign_q  <= ignore_uv;
    end
  end

  chip_diag_t                 c_diag [N_CHIPS];
  logic [8*N_CHIPS-1:0]       c_bits;

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_chip
    logic [7:0] d_sel, s_sel;
    logic       pin_i;
    // last received byte sits in the low 8 bits of the buffer
    assign d_sel = mode_q ? rxb[(2*N_CHIPS-1-2*i)*8 +: 8] : rxb[(N_CHIPS-1-i)*8 +: 8];
    assign s_sel = rxb[(2*N_CHIPS-2-2*i)*8 +: 8];
    if (SHARED_FAULT != 0) begin : g_shared
      assign pin_i = fault_pin[0];
    end else begin : g_own
      assign pin_i = fault_pin[i];
    end
    sser_chip_eval u_ev (
      .st_mode(mode_q), .ign_uv(ign_q), .data(d_sel), .stat(s_sel),
      .pin(pin_i), .diag(c_diag[i]), .bits(c_bits[8*i +: 8])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      in_bits    <= '0;
      chip_fault <= '0;
      crc_err    <= '0;
      over_temp  <= '0;
      uv_alarm   <= '0;
      uv_warn    <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        in_bits <= c_bits;
        for (int i = 0; i < N_CHIPS; i++) begin
          chip_fault[i] <= c_diag[i].flt;
          crc_err[i]    <= c_diag[i].crc_bad;
          over_temp[i]  <= c_diag[i].hot;
          uv_alarm[i]   <= c_diag[i].uv_al;
          uv_warn[i]    <= c_diag[i].uv_wn;
        end
      end
    end
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);  // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R2
  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(in_bits) && $stable(chip_fault) && $stable(crc_err)));  // R11
  AST_DATAONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(mode_q)) |-> (crc_err == '0 && over_temp == '0 && uv_alarm == '0));  // R8
  AST_IGNORE_UV_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(ign_q)) |-> (uv_alarm == '0 && uv_warn == '0));  // R7

endmodule

// File: tb/sim_sser_chain_rd.sv
module sim_sser_chain_rd;
  localparam int N  = 3;
  localparam int CD = 2;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic status_mode = 1, ignore_uv = 0, req_valid = 0, miso = 0;
  logic [N-1:0] fpin = '0;
  logic         fsh  = 0;

  logic req_ready, sclk, cs_n, done;
  logic [8*N-1:0] in_bits;
  logic [N-1:0] chip_fault, crc_err, over_temp, uv_alarm, uv_warn;
  logic rr1, sclk1, cs1, done1;
  logic [8*N-1:0] in_bits1;
  logic [N-1:0] flt1, crc1, ot1, uva1, uvw1;

  sser_chain_rd #(.N_CHIPS(N), .CLK_DIV(CD), .SHARED_FAULT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .status_mode(status_mode), .ignore_uv(ignore_uv),
    .req_valid(req_valid), .req_ready(req_ready), .sclk(sclk), .cs_n(cs_n),
    .miso(miso), .fault_pin(fpin), .done(done), .in_bits(in_bits),
    .chip_fault(chip_fault), .crc_err(crc_err), .over_temp(over_temp),
    .uv_alarm(uv_alarm), .uv_warn(uv_warn));

  sser_chain_rd #(.N_CHIPS(N), .CLK_DIV(CD), .SHARED_FAULT(1)) u1 (
    .clk(clk), .rst_n(rst_n), .status_mode(status_mode), .ignore_uv(ignore_uv),
    .req_valid(req_valid), .req_ready(rr1), .sclk(sclk1), .cs_n(cs1),
    .miso(miso), .fault_pin(fsh), .done(done1), .in_bits(in_bits1),
    .chip_fault(flt1), .crc_err(crc1), .over_temp(ot1),
    .uv_alarm(uva1), .uv_warn(uvw1));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [7:0] d);
    int r = d;
    for (int b = 0; b < 8; b++) begin
      r = r << 1;
      if (r & 256) r = (r ^ 'h1A8) & 255;
    end
    return 8'(r) & 8'hF8;
  endfunction

  // ---- chain slave model: bytes shifted MSB first, mode 0
  logic [7:0] fr [0:2*N-1];
  int nbytes = 2*N;
  int pbit = 0;
  always @(negedge cs_n) begin pbit = 0; miso = fr[0][7]; end
  always @(negedge sclk) if (!cs_n) begin
    pbit++;
    if (pbit < nbytes*8) miso = fr[pbit/8][7 - pbit%8];
  end

  // ---- behavioural cycle model
  int cnt = 0;
  bit m_ready = 1, m_done = 0, m_mode = 0, m_ign = 0;
  logic [8*N-1:0] e_bits = '0, e_bits1 = '0;
  logic [N-1:0] e_flt = '0, e_crc = '0, e_ot = '0, e_uva = '0, e_uvw = '0, e_flt1 = '0;

  task automatic compute();
    for (int i = 0; i < N; i++) begin
      logic [7:0] d, s;
      bit ce, ot, ua, uw, f, f1;
      d  = m_mode ? fr[2*i] : fr[i];
      s  = m_mode ? fr[2*i+1] : 8'h00;
      ce = m_mode && ((s & 8'hF8) != crc_ref(d));
      ot = m_mode && s[1];
      ua = m_mode && !m_ign && !s[2];
      uw = m_mode && !m_ign && !s[0];
      f  = (!m_ign && fpin[i]) || ce || ot || ua;
      f1 = (!m_ign && fsh) || ce || ot || ua;
      e_crc[i] = ce; e_ot[i] = ot; e_uva[i] = ua; e_uvw[i] = uw;
      e_flt[i] = f;  e_flt1[i] = f1;
      e_bits[8*i +: 8]  = f  ? 8'h00 : d;
      e_bits1[8*i +: 8] = f1 ? 8'h00 : d;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 0; m_ready = 1; m_done = 0;
    end else begin
      bit pre_ready;
      pre_ready = m_ready;
      m_done = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 1) m_ready = 1;
        if (cnt == 0) begin m_done = 1; compute(); end
      end
      if (req_valid && pre_ready) begin
        cnt = 2*CD*8*N*(status_mode ? 2 : 1) + 1;
        m_ready = 0; m_mode = status_mode; m_ign = ignore_uv;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R1 req_ready", 64'(req_ready), 64'(m_ready));
    chk("R2 cs_n", 64'(cs_n), 64'(!(cnt > 1 || (cnt == 1 && !m_ready))));
    chk("R2 done", 64'(done), 64'(m_done));
    chk("R2 sclk idle", 64'(cs_n && sclk), 64'(0));
    chk("R3 R10 R11 in_bits", 64'(in_bits), 64'(e_bits));
    chk("R4 crc_err", 64'(crc_err), 64'(e_crc));
    chk("R5 over_temp", 64'(over_temp), 64'(e_ot));
    chk("R6 R7 uv_alarm", 64'(uv_alarm), 64'(e_uva));
    chk("R6 R7 uv_warn", 64'(uv_warn), 64'(e_uvw));
    chk("R9 chip_fault", 64'(chip_fault), 64'(e_flt));
    chk("R9 shared chip_fault", 64'(flt1), 64'(e_flt1));
    chk("R9 R10 shared in_bits", 64'(in_bits1), 64'(e_bits1));
  end

  function automatic logic [7:0] st(input logic [7:0] d, input logic [2:0] fl);
    return crc_ref(d) | {5'b0, fl};
  endfunction

  task automatic run_frame(input bit mode, input int hold);
    while (!req_ready) @(negedge clk);
    status_mode = mode;
    nbytes = mode ? 2*N : N;
    req_valid = 1;
    repeat (hold) @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20*150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cs_n", 64'(cs_n), 64'(1));
    chk("R12 sclk", 64'(sclk), 64'(0));
    chk("R12 ready", 64'(req_ready), 64'(1));
    chk("R12 outputs", 64'({done, in_bits, chip_fault, crc_err, uv_warn}), 64'(0));
    rst_n = 1;
    @(negedge clk);

    // F1 all healthy, status mode
    fr[0] = 8'hA5; fr[1] = st(8'hA5, 3'b101);
    fr[2] = 8'h3C; fr[3] = st(8'h3C, 3'b101);
    fr[4] = 8'hF0; fr[5] = st(8'hF0, 3'b101);
    run_frame(1, 1);
    chk("R3 chip1 bits", 64'(in_bits[15:8]), 64'(8'h3C));

    // F2 chip1 bad code, chip2 hot
    fr[3] = st(8'h3C, 3'b101) ^ 8'h08;
    fr[5] = st(8'hF0, 3'b111);
    run_frame(1, 1);
    chk("R4 crc chip1", 64'(crc_err), 64'(3'b010));
    chk("R5 ot chip2", 64'(over_temp), 64'(3'b100));
    chk("R10 healthy chip0", 64'(in_bits), 64'(24'h0000A5));

    // F3 chip0 uv alarm, chip1 uv warning only
    fr[0] = 8'h00; fr[1] = st(8'h00, 3'b001);
    fr[2] = 8'hFF; fr[3] = st(8'hFF, 3'b100);
    fr[4] = 8'h5A; fr[5] = st(8'h5A, 3'b101);
    run_frame(1, 1);
    chk("R6 fault vec", 64'(chip_fault), 64'(3'b001));
    chk("R6 warn only", 64'(uv_warn), 64'(3'b010));

    // F4 same frame, undervoltage ignored, pins asserted
    ignore_uv = 1; fpin = 3'b100; fsh = 1;
    run_frame(1, 1);
    chk("R7 no fault", 64'(chip_fault), 64'(0));
    chk("R7 shared ignored", 64'(flt1), 64'(0));
    ignore_uv = 0;

    // F5 per-chip pin on chip1
    fpin = 3'b010; fsh = 0;
    fr[1] = st(8'h00, 3'b101); fr[3] = st(8'hFF, 3'b101);
    run_frame(1, 1);
    chk("R9 R10 chip1 masked", 64'(in_bits), 64'(24'h5A0000));

    // F6 data-only mode, pin on chip0
    fpin = 3'b001;
    fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33;
    run_frame(0, 1);
    chk("R8 flags clear", 64'({crc_err, over_temp, uv_alarm}), 64'(0));
    chk("R8 R3 data", 64'(in_bits), 64'(24'h332200));

    // F7 data-only, shared pin faults all chips of u1
    fpin = '0; fsh = 1;
    run_frame(0, 1);
    chk("R9 shared all", 64'(flt1), 64'(3'b111));
    fsh = 0;

    // F8 request held during transfer has no effect
    fr[0] = 8'h81; fr[1] = st(8'h81, 3'b101);
    fr[2] = 8'h42; fr[3] = st(8'h42, 3'b101);
    fr[4] = 8'h24; fr[5] = st(8'h24, 3'b101);
    run_frame(1, 40);
    chk("R1 R11 busy req", 64'(in_bits), 64'(24'h244281));

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule